// File: doc/BRIEF.md
# DMA Page Address Translator

This block turns bus addresses issued by DMA masters into physical addresses. It looks each address up in a single-level table of 64-bit entries held in on-chip RAM. The page size is chosen at run time by a shift value, and the number of usable table entries comes from a count input. An enable input switches the whole translation window off. Each entry carries its physical page frame in the bits above the page offset and an access permission in its two lowest bits.

A master presents a bus address on a valid/ready request port. Two cycles later the block returns four fields:

- the translated physical address, which is the entry with its page-offset bits cleared;
- the page-aligned I/O virtual address;
- the mask of the in-page offset bits;
- a two-bit permission.

Addresses beyond the configured window get a fixed fault response. Software or a loader fills the table through a simple write port. A synchronous reset invalidates every entry in one cycle, so every page faults until its entry is written again.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset every table entry reads as zero. An in-bounds lookup of an unwritten entry returns translated address 0 and permission 0, with its virtual address and address mask formed as in R4.
- R2: `req_ready` is low while `rst` is high and high otherwise. A request accepted at a clock edge has its response on the outputs with `rsp_valid` high after the second following edge, and for that one cycle only. Requests may be accepted on every cycle. `rsp_valid` is low whenever no request was accepted two edges earlier.
- R3: The table index is the bus address shifted right by the effective page shift. A request is in bounds only when that index is below the effective entry count.
- R4: Let M be the page mask, the complement of (2^shift − 1). An in-bounds response gives `rsp_xlate` = entry AND M, `rsp_iova` = bus address AND M, and `rsp_amask` = NOT M.
- R5: An out-of-bounds response gives `rsp_xlate` = 0, `rsp_iova` = 0, `rsp_amask` = all ones and `rsp_perm` = 0.
- R6: `rsp_perm` of an in-bounds response equals entry bits [1:0]. The codes are 0 = no access, 1 = read only, 2 = write only and 3 = read and write.
- R7: While `cfg_en` is low the effective shift and count are zero. Every lookup is then out of bounds and `win_bytes` is 0.
- R8: A `cfg_count` larger than the table depth (parameter DEPTH, default 1024) is treated as DEPTH. Index DEPTH−1 is then in bounds and index DEPTH is out of bounds.
- R9: `win_bytes` equals the effective entry count shifted left by the effective page shift.
- R10: A write and a lookup of the same entry in the same cycle make the lookup return the entry's previous contents. A lookup accepted on the next cycle returns the new contents.
- R11: A response uses the page shift, count and enable that were present on the cycle its request was accepted. Later changes to the configuration do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; invalidates all entries |
| cfg_en | input | 1 | Translation window enable |
| cfg_shift | input | 6 | Page shift (log2 of page size) |
| cfg_count | input | CNT_W (32) | Number of table entries in use |
| win_bytes | output | 64 | Size of the translation window in bytes |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W (10) | Entry index to write |
| wr_data | input | 64 | Entry value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | BA_W (48) | Bus address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_xlate | output | 64 | Translated physical page address |
| rsp_iova | output | BA_W (48) | Page-aligned bus address |
| rsp_amask | output | 64 | In-page offset mask |
| rsp_perm | output | 2 | Access permission |

## Verification
A table write and a lookup can hit the same entry in the same cycle. The bench provokes this by driving a write strobe and an accepted request for that index on one clock edge. The first response must carry the entry's old value and permission. A lookup on the very next cycle must show the new value. A second overlap is a configuration change on the cycle after a request is accepted, while that request is still in the pipeline. It is judged by checking that the earlier response keeps the older page shift while the following request uses the new one.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int ENTRY_W = 64;
  localparam int SHIFT_W = $clog2(ENTRY_W);

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  // Bits at and above the page offset are ones.
  function automatic logic [ENTRY_W-1:0] page_mask(input logic [SHIFT_W-1:0] sh);
    page_mask = ~((64'd1 << sh) - 64'd1);
  endfunction

  function automatic perm_e perm_of(input logic [ENTRY_W-1:0] ent);
    perm_of = perm_e'(ent[1:0]);
  endfunction

endpackage

// File: rtl/dpx_cfg.sv
module dpx_cfg
  import dpx_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic [SHIFT_W-1:0] eff_shift,
  output logic [CNT_W-1:0]   eff_count,
  output logic [63:0]        win_bytes
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
    clamp_cnt = (c > DEPTH_C) ? DEPTH_C : c;
  endfunction

  always_comb begin
    if (cfg_en) begin
      eff_shift = cfg_shift;
      eff_count = clamp_cnt(cfg_count);
    end else begin
      eff_shift = '0;
      eff_count = '0;
    end
    win_bytes = 64'(eff_count) << eff_shift;
  end

  // R8: the count in use never exceeds the table depth
  a_r8_count_clamped: assert property (@(posedge clk) disable iff (rst)
    eff_count <= DEPTH_C);

  // R9: an empty window has no bytes
  a_r9_empty_window: assert property (@(posedge clk) disable iff (rst)
    (eff_count == '0) |-> (win_bytes == 64'd0));

endmodule

// File: rtl/dpx_index.sv
module dpx_index
  import dpx_pkg::*;
#(
  parameter int BA_W  = 48,
  parameter int CNT_W = 32,
  parameter int IDX_W = 10
) (
  input  logic [BA_W-1:0]    addr,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CNT_W-1:0]   count,
  output logic [IDX_W-1:0]   idx,
  output logic               in_bounds
);

  localparam int CMP_W = (BA_W > CNT_W) ? BA_W : CNT_W;

  function automatic logic [BA_W-1:0] page_index(input logic [BA_W-1:0] a,
                                                 input logic [SHIFT_W-1:0] s);
    page_index = a >> s;
  endfunction

  logic [BA_W-1:0] idx_full;

  always_comb begin
    idx_full  = page_index(addr, shift);
    idx       = idx_full[IDX_W-1:0];
    in_bounds = CMP_W'(idx_full) < CMP_W'(count);
  end

endmodule

// File: rtl/dpx_table.sv
module dpx_table
  import dpx_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]   live_q;
  logic [ENTRY_W-1:0] rd_q;
  logic               rd_live_q;
  logic               wr_ok;
  logic               rd_ok;

  assign wr_ok = wr_en && !rst && (32'(wr_idx) < DEPTH);
  assign rd_ok = rd_en && (32'(rd_idx) < DEPTH);

  // Entry storage: plain RAM, no reset.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_data;
  end

  // Validity flags give a one-cycle clear of the whole table.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (wr_ok) begin
      live_q[wr_idx] <= 1'b1;
    end
  end

  // Registered read port returns the contents before a same-cycle write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_live_q <= 1'b0;
      rd_q      <= '0;
    end else if (rd_ok) begin
      rd_live_q <= live_q[rd_idx];
      rd_q      <= mem[rd_idx];
    end else begin
      rd_live_q <= 1'b0;
    end
  end

  assign rd_entry = rd_live_q ? rd_q : '0;

  // R10: a written entry is live on the following cycle
  a_r10_write_marks_live: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> live_q[$past(wr_idx)]);

  // R1: a read in the first cycle after reset sees no live entry
  a_r1_clear_on_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (live_q == '0));

endmodule

// File: rtl/dpx_resp.sv
module dpx_resp
  import dpx_pkg::*;
#(
  parameter int BA_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s0_fire,
  input  logic               s0_inb,
  input  logic [BA_W-1:0]    s0_addr,
  input  logic [SHIFT_W-1:0] s0_shift,
  input  logic [ENTRY_W-1:0] s1_entry,
  output logic               s1_valid,
  output logic               s1_inb,
  output logic               rsp_valid,
  output logic [ENTRY_W-1:0] rsp_xlate,
  output logic [BA_W-1:0]    rsp_iova,
  output logic [ENTRY_W-1:0] rsp_amask,
  output logic [1:0]         rsp_perm
);

  logic [BA_W-1:0]    s1_addr;
  logic [SHIFT_W-1:0] s1_shift;
  logic [ENTRY_W-1:0] s1_mask;
  logic [ENTRY_W-1:0] nx_xlate;
  logic [BA_W-1:0]    nx_iova;
  logic [ENTRY_W-1:0] nx_amask;
  perm_e              nx_perm;

  // Stage 1: request fields travel alongside the RAM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_inb   <= 1'b0;
      s1_addr  <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= s0_fire;
      if (s0_fire) begin
        s1_inb   <= s0_inb;
        s1_addr  <= s0_addr;
        s1_shift <= s0_shift;
      end
    end
  end

  always_comb begin
    s1_mask = page_mask(s1_shift);
    if (s1_inb) begin
      nx_xlate = s1_entry & s1_mask;
      nx_iova  = s1_addr & s1_mask[BA_W-1:0];
      nx_amask = ~s1_mask;
      nx_perm  = perm_of(s1_entry);
    end else begin
      nx_xlate = '0;
      nx_iova  = '0;
      nx_amask = '1;
      nx_perm  = PERM_NONE;
    end
  end

  // Stage 2: registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_xlate <= '0;
      rsp_iova  <= '0;
      rsp_amask <= '1;
      rsp_perm  <= PERM_NONE;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_xlate <= nx_xlate;
        rsp_iova  <= nx_iova;
        rsp_amask <= nx_amask;
        rsp_perm  <= nx_perm;
      end
    end
  end

  // R2: an accepted request reaches stage 1 on the next edge
  a_r2_stage1_follows: assert property (@(posedge clk) disable iff (rst)
    s0_fire |=> s1_valid);

  // R2: stage 1 turns into a response on the next edge
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> rsp_valid);

  // R2: no response appears without a request in stage 1
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !rsp_valid);

  // R4: translated and virtual addresses carry no in-page offset bits
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (((rsp_xlate & rsp_amask) == '0) &&
                   ((rsp_iova & rsp_amask[BA_W-1:0]) == '0)));

  // R5: a full mask only comes with the fault pattern
  a_r5_fault_shape: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_amask == '1)) |->
      ((rsp_xlate == '0) && (rsp_iova == '0) && (rsp_perm == 2'd0)));

endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate
  import dpx_pkg::*;
#(
  parameter int BA_W  = 48,
  parameter int DEPTH = 1024,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic [63:0]        win_bytes,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BA_W-1:0]    req_addr,
  output logic               rsp_valid,
  output logic [ENTRY_W-1:0] rsp_xlate,
  output logic [BA_W-1:0]    rsp_iova,
  output logic [ENTRY_W-1:0] rsp_amask,
  output logic [1:0]         rsp_perm
);

  logic [SHIFT_W-1:0] eff_shift;
  logic [CNT_W-1:0]   eff_count;
  logic [IDX_W-1:0]   look_idx;
  logic               look_inb;
  logic               req_fire;
  logic [ENTRY_W-1:0] tbl_entry;
  logic               s1_valid;
  logic               s1_inb;

  assign req_ready = !rst;
  assign req_fire  = req_valid && req_ready;

  dpx_cfg #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_shift (cfg_shift),
    .cfg_count (cfg_count),
    .eff_shift (eff_shift),
    .eff_count (eff_count),
    .win_bytes (win_bytes)
  );

  dpx_index #(.BA_W(BA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_index (
    .addr      (req_addr),
    .shift     (eff_shift),
    .count     (eff_count),
    .idx       (look_idx),
    .in_bounds (look_inb)
  );

  dpx_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_en    (req_fire && look_inb),
    .rd_idx   (look_idx),
    .rd_entry (tbl_entry)
  );

  dpx_resp #(.BA_W(BA_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .s0_fire   (req_fire),
    .s0_inb    (look_inb),
    .s0_addr   (req_addr),
    .s0_shift  (eff_shift),
    .s1_entry  (tbl_entry),
    .s1_valid  (s1_valid),
    .s1_inb    (s1_inb),
    .rsp_valid (rsp_valid),
    .rsp_xlate (rsp_xlate),
    .rsp_iova  (rsp_iova),
    .rsp_amask (rsp_amask),
    .rsp_perm  (rsp_perm)
  );

  // R7: a request accepted while disabled is out of bounds
  a_r7_disabled_faults: assert property (@(posedge clk) disable iff (rst)
    (req_fire && !cfg_en) |=> (s1_valid && !s1_inb));

  // R2: the request port is never ready during reset
  a_r2_ready_in_reset: assert property (@(posedge clk)
    rst |-> !req_ready);

endmodule

// File: tb/dma_page_xlate_test.sv
module dma_page_xlate_test;

  localparam int BA_W  = 48;
  localparam int DEPTH = 1024;
  localparam int CNT_W = 32;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             cfg_en = 1'b0;
  logic [5:0]       cfg_shift = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic [63:0]      win_bytes;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [63:0]      wr_data = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [BA_W-1:0]  req_addr = '0;
  logic             rsp_valid;
  logic [63:0]      rsp_xlate;
  logic [BA_W-1:0]  rsp_iova;
  logic [63:0]      rsp_amask;
  logic [1:0]       rsp_perm;

  dma_page_xlate #(.BA_W(BA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst),
    .cfg_en(cfg_en), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
    .win_bytes(win_bytes),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_xlate(rsp_xlate), .rsp_iova(rsp_iova),
    .rsp_amask(rsp_amask), .rsp_perm(rsp_perm)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] model [DEPTH];

  // Configuration to apply on the next drive.
  logic             n_en  = 1'b0;
  logic [5:0]       n_sh  = '0;
  logic [CNT_W-1:0] n_cnt = '0;

  // Expected responses: p0 driven on the last step, p1 two steps back.
  logic            p0_v = 1'b0, p1_v = 1'b0;
  logic [63:0]     p0_xl, p1_xl, p0_am, p1_am;
  logic [BA_W-1:0] p0_va, p1_va;
  logic [1:0]      p0_pm, p1_pm;
  string           p0_tag = "R2", p1_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] offs_mask(input int sh);
    logic [63:0] m = '0;
    for (int b = 0; b < sh; b++) m[b] = 1'b1;
    return m;
  endfunction

  task automatic check_out();
    if (p1_v) begin
      chk(rsp_valid === 1'b1, p1_tag, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_xlate === p1_xl, p1_tag, "rsp_xlate", rsp_xlate, p1_xl);
      chk(rsp_iova === p1_va, p1_tag, "rsp_iova", 64'(rsp_iova), 64'(p1_va));
      chk(rsp_amask === p1_am, p1_tag, "rsp_amask", rsp_amask, p1_am);
      chk(rsp_perm === p1_pm, p1_tag, "rsp_perm", 64'(rsp_perm), 64'(p1_pm));
    end else begin
      chk(rsp_valid === 1'b0, "R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    end
  endtask

  task automatic step(input bit v, input logic [BA_W-1:0] a, input bit w,
                      input int wi, input logic [63:0] wd, input string tag);
    int          esh;
    longint      ecnt;
    logic [63:0] pg, off, ent;
    @(negedge clk);
    check_out();
    p1_v = p0_v; p1_xl = p0_xl; p1_va = p0_va; p1_am = p0_am;
    p1_pm = p0_pm; p1_tag = p0_tag;
    esh  = n_en ? int'(n_sh) : 0;
    ecnt = n_en ? ((n_cnt > DEPTH) ? DEPTH : longint'(n_cnt)) : 0;
    pg   = 64'(a) / (64'd1 << esh);
    off  = offs_mask(esh);
    p0_v = v; p0_tag = tag;
    if (longint'(pg) < ecnt) begin
      ent   = model[pg[IDX_W-1:0]];
      p0_xl = ent - (ent & off);
      p0_va = a - (a & off[BA_W-1:0]);
      p0_am = off;
      p0_pm = ent[1:0];
    end else begin
      p0_xl = 64'd0; p0_va = '0; p0_am = {64{1'b1}}; p0_pm = 2'd0;
    end
    cfg_en = n_en; cfg_shift = n_sh; cfg_count = n_cnt;
    req_valid = v; req_addr = a;
    wr_en = w; wr_idx = IDX_W'(wi); wr_data = wd;
    if (w) model[wi] = wd;
  endtask

  task automatic look(input logic [BA_W-1:0] a, input string tag);
    step(1'b1, a, 1'b0, 0, 64'd0, tag);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 0, 64'd0, "R2");
  endtask

  task automatic put(input int i, input logic [63:0] d);
    step(1'b0, '0, 1'b1, i, d, "R4");
  endtask

  task automatic set_cfg(input bit en, input int sh, input int cnt);
    n_en = en; n_sh = 6'(sh); n_cnt = CNT_W'(cnt);
  endtask

  task automatic win_chk(input logic [63:0] exp, input string tag);
    #1;
    chk(win_bytes === exp, tag, "win_bytes", win_bytes, exp);
  endtask

  task automatic do_reset();
    idle(); idle(); idle();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; wr_en = 1'b0;
    p0_v = 1'b0; p1_v = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 64'd0;
    @(negedge clk);
    chk(req_ready === 1'b0, "R2", "req_ready in reset", 64'(req_ready), 64'd0);
    chk(rsp_valid === 1'b0, "R2", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready === 1'b1, "R2", "req_ready after reset", 64'(req_ready), 64'd1);
  endtask

  // R1: unwritten entries fault, including after a second reset
  task automatic t_reset_clear();
    set_cfg(1'b1, 12, 16);
    look(48'h0000_0000_0123, "R1");
    look(48'h0000_0000_5FFF, "R1");
    look(48'h0000_0000_F800, "R1");
    put(3, 64'h0000_00AB_CDE0_0003);
    look(48'h3004, "R1");
    do_reset();
    look(48'h3004, "R1");
    idle(); idle();
  endtask

  // R4 R6 R2: all permission codes, back-to-back lookups
  task automatic t_perm_codes();
    set_cfg(1'b1, 12, 16);
    put(0, 64'h1111_2222_3333_4FF0);
    put(1, 64'h0000_0012_3456_7AB1);
    put(2, 64'hFEDC_BA98_7654_3FF2);
    put(3, 64'h0000_0000_8000_0003);
    look(48'h0000_0000_0ABC, "R6");
    look(48'h0000_0000_1FFF, "R6");
    look(48'h0000_0000_2001, "R6");
    look(48'h0000_0000_3800, "R4");
    idle(); idle();
  endtask

  // R3 R4: other page shifts
  task automatic t_shifts();
    set_cfg(1'b1, 16, 16);
    look(48'h0000_0003_0123, "R3");
    look(48'h0000_0001_FFFF, "R3");
    set_cfg(1'b1, 0, 16);
    look(48'h0000_0000_0002, "R4");
    look(48'h0000_0000_0010, "R3");
    idle(); idle();
  endtask

  // R5 R3: window edge
  task automatic t_bounds();
    set_cfg(1'b1, 12, 4);
    look(48'h0000_0000_3FFF, "R3");
    look(48'h0000_0000_4000, "R5");
    look(48'hFFFF_FFFF_FFFF, "R5");
    idle(); idle();
  endtask

  // R8 R9: clamping to the depth
  task automatic t_clamp();
    set_cfg(1'b1, 12, 5000);
    put(DEPTH - 1, 64'h0000_7777_0000_0003);
    win_chk(64'(DEPTH) << 12, "R9");
    look(48'(DEPTH - 1) << 12, "R8");
    look(48'(DEPTH) << 12, "R8");
    set_cfg(1'b1, 20, 16);
    idle();
    win_chk(64'd16 << 20, "R9");
    idle();
  endtask

  // R7: disabled window
  task automatic t_disabled();
    set_cfg(1'b0, 12, 16);
    look(48'h0000_0000_0000, "R7");
    win_chk(64'd0, "R7");
    look(48'h0000_0000_1000, "R7");
    idle(); idle();
  endtask

  // R10: same-cycle write and lookup of one entry
  task automatic t_collision();
    set_cfg(1'b1, 12, 16);
    put(5, 64'h0000_0000_AAAA_A001);
    step(1'b1, 48'h5123, 1'b1, 5, 64'h0000_0000_BBBB_B003, "R10");
    look(48'h5456, "R10");
    idle(); idle();
  endtask

  // R11: config change while a request is in flight
  task automatic t_cfg_hold();
    set_cfg(1'b1, 12, 16);
    put(1, 64'h0000_0000_CCCC_C002);
    look(48'h0000_0000_1ABC, "R11");
    set_cfg(1'b1, 16, 16);
    look(48'h0000_0001_ABCD, "R11");
    set_cfg(1'b0, 16, 16);
    idle();
    idle(); idle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 64'd0;
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b0, "R2", "req_ready at start", 64'(req_ready), 64'd0);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid at start", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    t_reset_clear();
    t_perm_codes();
    t_shifts();
    t_bounds();
    t_clamp();
    t_disabled();
    t_collision();
    t_cfg_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule